// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block produces the chip-level reset from four causes: the power-on release, an external active-low reset pin, a watchdog that has not been serviced in time, and a monitor that finds the bus clock has stopped. It holds the reset for a fixed time after power-on and stretches it past the end of any later cause. When the reset is released it sends the CPU a single-cycle start pulse. That pulse tells the CPU to set its stop, non-maskable and maskable interrupt mask bits and to fetch the vector for the cause, which the block reports on a vector select.

Sticky cause flags record every cause seen since the last power-on, so software can read them after reset. The clock monitor runs on a slow reference clock of its own. Because a reset that waits for a dead bus clock would never arrive, its failure signal drives the reset output directly.

Top module: `sysreset_ctrl`

## Requirements
- R1: While `por_n` is low the block is in reset, `cause` reads 4'b0001 and `sys_rst_n` is low. After `por_n` is seen high, `sys_rst_n` stays low for 4064 bus clock edges. It goes high on the 4064th edge with `cpu_init` high and `vec_sel` = 0.
- R2: `rst_pin_n` passes through a two-stage synchronizer. It causes a reset only when the synchronized level is low for 6 consecutive bus cycles. A low pulse of 5 cycles has no effect.
- R3: After the last cycle in which any cause is active, `sys_rst_n` stays low for 16 more bus cycles. For the pin, it goes high 18 bus edges after the pin returns high.
- R4: With `wd_en` high and no service, the watchdog forces a reset 2^WD_EXP × {1, 2, 4, 4} bus cycles after it starts counting, for `wd_rate` = 0, 1, 2, 3. WD_EXP defaults to 15. With `wd_en` low it never fires.
- R5: A write of 8'h55 followed by a write of 8'hAA (`svc_wr` strobes carrying `svc_data`) restarts the watchdog count. A lone 8'hAA, or 8'h55 followed by any other value, does not restart it.
- R6: `cpu_init` is a one-cycle pulse in the first cycle of every reset release and is low at all other times.
- R7: `vec_sel` holds the highest-priority cause seen during the reset episode: 0 = power-on or pin, 1 = clock monitor, 2 = watchdog. The pin outranks the clock monitor, and the clock monitor outranks the watchdog, whatever order they arrive in.
- R8: Each cause bit in `cause` is set when its cause resets the chip: bit0 power-on, bit1 pin, bit2 clock monitor, bit3 watchdog. The bits stay set through later resets and are cleared only by `por_n` low.
- R9: With `cmon_en` high, if the bus clock shows no activity for 8 `ref_clk` ticks, `sys_rst_n` goes low even while the bus clock is stopped. Bit2 and `vec_sel` = 1 are recorded once the clock returns. With `cmon_en` low, a stopped bus clock has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| ref_clk | input | 1 | Independent slow reference clock for the clock monitor |
| por_n | input | 1 | Power-on reset from the analog detector, active low, sampled synchronously |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wd_en | input | 1 | Watchdog enable |
| wd_rate | input | 2 | Watchdog period multiplier select |
| svc_wr | input | 1 | Watchdog service write strobe |
| svc_data | input | 8 | Watchdog service write data |
| cmon_en | input | 1 | Clock monitor enable |
| sys_rst_n | output | 1 | System reset, active low |
| cause | output | 4 | Sticky reset cause flags |
| cpu_init | output | 1 | Release pulse: set S, X, I masks and fetch the vector |
| vec_sel | output | 2 | Vector select for the reset cause |

## Verification
The results fall due at fixed edges. Power-on release comes on the 4064th edge after `por_n` rises. A pin reset takes effect two edges after a 6-cycle low pulse ends, and a pin release completes 18 edges after the pin rises. A watchdog reset lands one edge after the counter reaches the period minus one. The bench counts these edges exactly: it samples 2 ns after the edge, checks the level one edge before the due edge, and then checks the new level on the due edge. The clock-monitor results depend on two unrelated clocks, so those checks wait for tens of bus cycles of margin, and the level during a stopped clock is sampled while the clock is still stopped.

// File: rtl/sysreset_pkg.sv
// Shared types for the system reset controller.
package sysreset_pkg;

    // Sequencer states: power-on stabilisation, stretched reset, running.
    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    // Vector select; a lower code means higher priority.
    typedef enum logic [1:0] {
        VEC_RESET  = 2'd0,
        VEC_CLKMON = 2'd1,
        VEC_WDOG   = 2'd2
    } vec_sel_t;

    localparam int CAUSE_W      = 4;
    localparam int CAUSE_POR    = 0;
    localparam int CAUSE_PIN    = 1;
    localparam int CAUSE_CLKMON = 2;
    localparam int CAUSE_WDOG   = 3;

endpackage

// File: rtl/pin_filter.sv
// pin_filter: synchronizes the external reset pin and accepts it only
// after PIN_MIN consecutive low samples.
// Assumes: rst_n is the synchronous active-low power-on reset.
module pin_filter #(
    parameter int PIN_MIN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_req
);
    localparam int CW = $clog2(PIN_MIN + 1);

    logic [1:0]    sync_q;
    logic          pin_s;
    logic [CW-1:0] low_cnt;

    assign pin_s = sync_q[1];

    // Two-stage synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], pin_n};
    end

    // Count consecutive low samples, saturating one short of the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n || pin_s)                low_cnt <= '0;
        else if (low_cnt < CW'(PIN_MIN - 1)) low_cnt <= low_cnt + 1'b1;
    end

    assign pin_req = !pin_s && (low_cnt == CW'(PIN_MIN - 1));

    AST_PIN_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pin_req |-> (!pin_s && !$past(pin_s, 1) && !$past(pin_s, 2) &&
                     !$past(pin_s, 3) && !$past(pin_s, 4) && !$past(pin_s, 5))); // R2

endmodule

// File: rtl/wdog_timer.sv
// wdog_timer: watchdog period counter with a two-write service key.
// Period = 2^WD_EXP times 1, 2 or 4 bus cycles, selected by rate.
// Assumes: hold is high while the system is in reset; the count restarts then.
module wdog_timer #(
    parameter int         WD_EXP = 15,
    parameter logic [7:0] KEY1   = 8'h55,
    parameter logic [7:0] KEY2   = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       en,
    input  logic [1:0] rate,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       timeout
);
    localparam int CW = WD_EXP + 3;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit_m1;
    logic          armed;
    logic          svc_ok;

    // Terminal count for the selected multiplier.
    always_comb begin
        case (rate)
            2'd0:    limit_m1 = (CW'(1) << WD_EXP) - 1'b1;
            2'd1:    limit_m1 = (CW'(1) << (WD_EXP + 1)) - 1'b1;
            default: limit_m1 = (CW'(1) << (WD_EXP + 2)) - 1'b1;
        endcase
    end

    // A first-key write arms the service; any other write disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || !en) armed <= 1'b0;
        else if (svc_wr)           armed <= (svc_data == KEY1);
    end

    assign svc_ok = en && svc_wr && armed && (svc_data == KEY2);

    // Period counter, restarted by reset, disable or a valid service.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || !en || svc_ok) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end

    assign timeout = en && !hold && (cnt == limit_m1);

    AST_WD_SERVICE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !timeout); // R5

endmodule

// File: rtl/clk_monitor.sv
// clk_monitor: detects a stopped bus clock using the reference clock.
// The ref domain toggles a request, the bus domain echoes it back. If no
// echo completes within TICKS reference ticks, the clock is declared lost.
// Assumes: ref_clk runs whenever the chip is powered; rst_n is held for
// several ref_clk ticks at power-on.
module clk_monitor #(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic ref_clk,
    input  logic rst_n,
    input  logic en,
    output logic fail_ref,
    output logic fail_bus
);
    localparam int CW = $clog2(TICKS + 1);

    logic          req_q;
    logic [1:0]    echo_sync;
    logic [1:0]    ack_sync;
    logic [1:0]    en_sync;
    logic [1:0]    fail_sync;
    logic [CW-1:0] idle_cnt;
    logic          round_done;

    // Bus side: echo the reference request back through a synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) echo_sync <= 2'b00;
        else        echo_sync <= {echo_sync[0], req_q};
    end

    // Ref side: synchronize the echo and the enable.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            ack_sync <= 2'b00;
            en_sync  <= 2'b00;
        end else begin
            ack_sync <= {ack_sync[0], echo_sync[1]};
            en_sync  <= {en_sync[0], en};
        end
    end

    assign round_done = (ack_sync[1] == req_q);

    // Ref side: issue a new request per completed round, count idle ticks.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            idle_cnt <= '0;
        end else begin
            if (round_done) req_q <= ~req_q;
            if (!en_sync[1] || round_done)  idle_cnt <= '0;
            else if (idle_cnt != CW'(TICKS)) idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign fail_ref = (idle_cnt == CW'(TICKS));

    // Bus side: bring the failure into the bus domain for the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) fail_sync <= 2'b00;
        else        fail_sync <= {fail_sync[0], fail_ref};
    end

    assign fail_bus = fail_sync[1];

    AST_CMON_DISABLED_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !en_sync[1] |=> !fail_ref); // R9

endmodule

// File: rtl/rst_sequencer.sv
// rst_sequencer: power-on delay, reset stretch, cause flags, priority
// vector select and the release pulse to the CPU.
// Assumes: cause requests are already synchronous to clk.
module rst_sequencer
    import sysreset_pkg::*;
#(
    parameter int POR_CYC  = 4064,
    parameter int HOLD_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_req,
    input  logic               cmon_req,
    input  logic               wd_req,
    output logic               rst_q_n,
    output logic               cpu_init,
    output logic [1:0]         vec_sel,
    output logic [CAUSE_W-1:0] cause
);
    localparam int CW = $clog2(POR_CYC + 1);

    seq_state_t         state_q;
    vec_sel_t           vec_q;
    vec_sel_t           prio;
    logic [CW-1:0]      cnt_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] hit;
    logic               any_req;
    logic               init_q;

    // Priority encode of the causes active this cycle.
    always_comb begin
        if (pin_req)       prio = VEC_RESET;
        else if (cmon_req) prio = VEC_CLKMON;
        else               prio = VEC_WDOG;
    end

    // Cause bits raised this cycle.
    always_comb begin
        hit               = '0;
        hit[CAUSE_PIN]    = pin_req;
        hit[CAUSE_CLKMON] = cmon_req;
        hit[CAUSE_WDOG]   = wd_req;
    end

    assign any_req = pin_req || cmon_req || wd_req;

    // Main sequencing: power-on count, stretch, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_POR;
            cnt_q   <= '0;
            cause_q <= CAUSE_W'(1) << CAUSE_POR;
            vec_q   <= VEC_RESET;
            init_q  <= 1'b0;
        end else begin
            init_q <= 1'b0;
            case (state_q)
                ST_POR: begin
                    if (cnt_q == CW'(POR_CYC - 1)) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                        init_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (any_req) begin
                        state_q <= ST_HOLD;
                        cnt_q   <= '0;
                        cause_q <= cause_q | hit;
                        vec_q   <= prio;
                    end
                end
                ST_HOLD: begin
                    if (any_req) begin
                        cnt_q   <= '0;
                        cause_q <= cause_q | hit;
                        if (prio < vec_q) vec_q <= prio;
                    end else if (cnt_q == CW'(HOLD_CYC - 1)) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                        init_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_POR;
            endcase
        end
    end

    assign rst_q_n  = (state_q == ST_RUN);
    assign cpu_init = init_q;
    assign vec_sel  = vec_q;
    assign cause    = cause_q;

    AST_INIT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_init |-> (rst_q_n && !$past(rst_q_n))); // R6
    AST_PIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_req && state_q != ST_POR) |=> (vec_q == VEC_RESET && !rst_q_n)); // R7
    AST_CMON_OVER_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmon_req && state_q != ST_POR) |=> (vec_q != VEC_WDOG)); // R7
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cause_q) & ~cause_q) == '0)); // R8

endmodule

// File: rtl/sysreset_ctrl.sv
// sysreset_ctrl: system reset generator combining power-on, pin,
// clock-monitor and watchdog causes.
// Assumes: por_n comes from an analog detector and is held low for several
// ref_clk ticks; the bus clock runs while por_n is low.
module sysreset_ctrl
    import sysreset_pkg::*;
#(
    parameter int POR_CYC    = 4064,
    parameter int HOLD_CYC   = 16,
    parameter int PIN_MIN    = 6,
    parameter int WD_EXP     = 15,
    parameter int CMON_TICKS = 8
) (
    input  logic               clk,
    input  logic               ref_clk,
    input  logic               por_n,
    input  logic               rst_pin_n,
    input  logic               wd_en,
    input  logic [1:0]         wd_rate,
    input  logic               svc_wr,
    input  logic [7:0]         svc_data,
    input  logic               cmon_en,
    output logic               sys_rst_n,
    output logic [CAUSE_W-1:0] cause,
    output logic               cpu_init,
    output logic [1:0]         vec_sel
);
    logic pin_req;
    logic wd_req;
    logic cmon_fail_ref;
    logic cmon_fail_bus;
    logic seq_rst_n;

    pin_filter #(.PIN_MIN(PIN_MIN)) u_pin (
        .clk     (clk),
        .rst_n   (por_n),
        .pin_n   (rst_pin_n),
        .pin_req (pin_req)
    );

    wdog_timer #(.WD_EXP(WD_EXP)) u_wdog (
        .clk      (clk),
        .rst_n    (por_n),
        .hold     (!seq_rst_n),
        .en       (wd_en),
        .rate     (wd_rate),
        .svc_wr   (svc_wr),
        .svc_data (svc_data),
        .timeout  (wd_req)
    );

    clk_monitor #(.TICKS(CMON_TICKS)) u_cmon (
        .clk      (clk),
        .ref_clk  (ref_clk),
        .rst_n    (por_n),
        .en       (cmon_en),
        .fail_ref (cmon_fail_ref),
        .fail_bus (cmon_fail_bus)
    );

    rst_sequencer #(.POR_CYC(POR_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (por_n),
        .pin_req  (pin_req),
        .cmon_req (cmon_fail_bus),
        .wd_req   (wd_req),
        .rst_q_n  (seq_rst_n),
        .cpu_init (cpu_init),
        .vec_sel  (vec_sel),
        .cause    (cause)
    );

    // Clock loss drives the reset directly: a dead bus clock cannot.
    assign sys_rst_n = seq_rst_n && !cmon_fail_ref;

endmodule

// File: tb/sysreset_ctrl_bench.sv
// Directed bench for sysreset_ctrl; one task per scenario.
module sysreset_ctrl_bench;
    localparam int WDX = 10;

    logic       clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       por_n = 1'b0;
    logic       rst_pin_n = 1'b1;
    logic       wd_en = 1'b0;
    logic [1:0] wd_rate = 2'd0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       cmon_en = 1'b0;
    logic       sys_rst_n;
    logic [3:0] cause;
    logic       cpu_init;
    logic [1:0] vec_sel;

    int checks = 0;
    int errors = 0;

    sysreset_ctrl #(.WD_EXP(WDX)) u_sysreset_ctrl (
        .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
        .wd_en(wd_en), .wd_rate(wd_rate), .svc_wr(svc_wr), .svc_data(svc_data),
        .cmon_en(cmon_en), .sys_rst_n(sys_rst_n), .cause(cause),
        .cpu_init(cpu_init), .vec_sel(vec_sel)
    );

    // 125 MHz bus clock that can be stopped; 10 MHz reference clock.
    always begin #4; if (clk_run) clk = ~clk; end
    always #50 ref_clk = ~ref_clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic svc_write(input logic [7:0] d);
        svc_wr = 1'b1; svc_data = d;
        tick(1);
        svc_wr = 1'b0;
    endtask

    task automatic t_por_release();
        por_n = 1'b0;
        tick(40);
        chk("R1", "cause in reset", cause, 4'b0001);
        chk("R1", "sys_rst_n in reset", sys_rst_n, 0);
        por_n = 1'b1;
        tick(4063);
        chk("R1", "still held at 4063", sys_rst_n, 0);
        tick(1);
        chk("R1", "released at 4064", sys_rst_n, 1);
        chk("R6", "cpu_init on release", cpu_init, 1);
        chk("R1", "vec_sel after por", vec_sel, 0);
        tick(1);
        chk("R6", "cpu_init one cycle", cpu_init, 0);
    endtask

    task automatic t_pin_short();
        int lows = 0;
        rst_pin_n = 1'b0;
        tick(5);
        rst_pin_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            if (!sys_rst_n) lows++;
        end
        chk("R2", "5-cycle pulse ignored", lows, 0);
        chk("R2", "cause after short pulse", cause, 4'b0001);
    endtask

    task automatic t_pin_accept();
        rst_pin_n = 1'b0;
        tick(6);
        rst_pin_n = 1'b1;
        tick(2);
        chk("R2", "6-cycle pulse accepted", sys_rst_n, 0);
        tick(15);
        chk("R3", "stretch still held", sys_rst_n, 0);
        tick(1);
        chk("R3", "stretch released", sys_rst_n, 1);
        chk("R6", "cpu_init after pin", cpu_init, 1);
        chk("R8", "cause after pin", cause, 4'b0011);
        chk("R7", "vec after pin", vec_sel, 0);
    endtask

    task automatic t_pin_long_stretch();
        rst_pin_n = 1'b0;
        tick(50);
        chk("R2", "held pin keeps reset", sys_rst_n, 0);
        rst_pin_n = 1'b1;
        tick(17);
        chk("R3", "low 17 edges after pin rise", sys_rst_n, 0);
        tick(1);
        chk("R3", "high 18 edges after pin rise", sys_rst_n, 1);
    endtask

    task automatic t_pin_then_cmon();
        cmon_en = 1'b1;
        tick(60);
        rst_pin_n = 1'b0;
        tick(20);
        clk_run = 1'b0;
        #1500;
        clk_run = 1'b1;
        tick(60);
        rst_pin_n = 1'b1;
        tick(40);
        chk("R7", "released after both", sys_rst_n, 1);
        chk("R7", "pin outranks later cmon", vec_sel, 0);
        chk("R8", "both causes recorded", cause, 4'b0111);
    endtask

    task automatic t_cmon_only();
        clk_run = 1'b0;
        #1500;
        chk("R9", "reset while clock stopped", sys_rst_n, 0);
        clk_run = 1'b1;
        tick(80);
        chk("R9", "released after clock back", sys_rst_n, 1);
        chk("R9", "vec for clock loss", vec_sel, 1);
        chk("R8", "cause after cmon", cause, 4'b0111);
    endtask

    task automatic wd_finish(input string req);
        wd_en = 1'b0;
        tick(30);
        chk(req, "released after wdog", sys_rst_n, 1);
        chk("R7", "vec for watchdog", vec_sel, 2);
        chk("R8", "cause after wdog", cause, 4'b1111);
    endtask

    task automatic t_wd_rate(input logic [1:0] r, input int period);
        wd_rate = r;
        wd_en = 1'b1;
        tick(period - 1);
        chk("R4", "no timeout before period", sys_rst_n, 1);
        tick(1);
        chk("R4", "timeout at period", sys_rst_n, 0);
        wd_finish("R4");
    endtask

    task automatic t_wd_service();
        wd_rate = 2'd0;
        wd_en = 1'b1;
        tick(500);
        svc_write(8'h55);
        svc_write(8'hAA);
        tick(1023);
        chk("R5", "serviced count restarted", sys_rst_n, 1);
        tick(1);
        chk("R5", "timeout one period after service", sys_rst_n, 0);
        wd_finish("R5");
    endtask

    task automatic t_wd_bad_seq();
        wd_rate = 2'd0;
        wd_en = 1'b1;
        tick(500);
        svc_write(8'hAA);
        svc_write(8'h55);
        svc_write(8'h12);
        svc_write(8'hAA);
        tick(519);
        chk("R5", "bad sequence no early timeout", sys_rst_n, 1);
        tick(1);
        chk("R5", "bad sequence ignored", sys_rst_n, 0);
        wd_finish("R5");
    endtask

    task automatic t_wd_disabled();
        int lows = 0;
        wd_en = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            tick(1);
            if (!sys_rst_n) lows++;
        end
        chk("R4", "disabled watchdog quiet", lows, 0);
    endtask

    task automatic t_cmon_disabled();
        cmon_en = 1'b0;
        tick(60);
        clk_run = 1'b0;
        #1500;
        chk("R9", "disabled monitor quiet", sys_rst_n, 1);
        clk_run = 1'b1;
        tick(80);
        chk("R9", "no reset after restart", sys_rst_n, 1);
        chk("R9", "cause unchanged", cause, 4'b1111);
    endtask

    task automatic t_por_clears();
        por_n = 1'b0;
        tick(40);
        chk("R8", "power-on clears causes", cause, 4'b0001);
        por_n = 1'b1;
        tick(4064);
        chk("R1", "second por release", sys_rst_n, 1);
        chk("R1", "vec after second por", vec_sel, 0);
    endtask

    initial begin
        t_por_release();
        t_pin_short();
        t_pin_accept();
        t_pin_long_stretch();
        t_pin_then_cmon();
        t_cmon_only();
        t_wd_rate(2'd0, 1 << WDX);
        t_wd_rate(2'd1, 2 << WDX);
        t_wd_rate(2'd2, 4 << WDX);
        t_wd_service();
        t_wd_bad_seq();
        t_wd_disabled();
        t_cmon_disabled();
        t_por_clears();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule